// File: doc/BRIEF.md
# Configuration Port Unlock and Register Access Controller

This block models the device side of a legacy byte-wide configuration interface. A host sees two ports: a key/address port and a data port. Each port is driven by single-cycle strobes. While the block is locked, the key/address port feeds a sequence matcher. The block opens only after an exact four-byte key. The data port is inert until then.

Once the block is open, a byte written to the key/address port becomes the register index. Data-port writes and reads then act on that index. Indices below 0x30 form a global space that every logical device shares. Indices 0x30 and above are kept in a separate bank for each logical device. A global register picks which bank is in use. The host closes the port by writing a command value to a global register. All stored contents survive the close and are seen again at the next opening.

Top module: `cfg_port_ctrl`

## Requirements
- R1: The block enters configuration mode (`cfg_mode` = 1, one cycle after the fourth strobe) only after the bytes 0x87, 0x01, 0x55, 0x55 are written in that order through `key_wr` while locked.
- R2: A non-matching byte during the key sequence restarts the matcher. When that byte is 0x87, it counts as the first key byte, so 0x87 0x01 0x87 0x01 0x55 0x55 unlocks and 0x87 0x01 0x55 0x00 0x55 0x55 does not.
- R3: While locked, data-port writes change no register, and data-port reads return 0xFF.
- R4: While unlocked, a `key_wr` strobe loads `wdata` as the register index for the following data-port accesses.
- R5: A data write of 0x02 to index 0x02 returns the block to the locked state. Any other value written there leaves it unlocked. Index 0x02 reads as 0x00.
- R6: Index 0x07 holds the logical device number in its low 3 bits (higher written bits are dropped). It reads back zero-extended, and it selects the bank for indices 0x30 to 0xFF.
- R7: Index 0x20 reads 0x87 and index 0x21 reads 0x12, giving the identifier 0x8712 high byte first. Writes to these two indices have no effect.
- R8: Every other index from 0x00 to 0x2F is a read/write byte that all logical devices share.
- R9: Indices 0x30 to 0xFF are read/write bytes stored separately for each of the 8 logical devices.
- R10: Leaving configuration mode keeps every register, including the device number, and a later unlock reads them back unchanged.
- R11: Synchronous reset (`rst` = 1) locks the block, clears all registers, the index and the device number to 0x00, and sets `rdata` to 0xFF.
- R12: `rdata` takes the read value in the cycle after a `data_rd` strobe and holds it while no read strobe is given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| key_wr | input | 1 | Write strobe for the key/address port |
| data_wr | input | 1 | Write strobe for the data port |
| data_rd | input | 1 | Read strobe for the data port |
| wdata | input | 8 | Byte written by either write strobe |
| rdata | output | 8 | Registered data-port read result |
| cfg_mode | output | 1 | High while configuration mode is open |

## Verification
The bench uses the default of 8 logical devices, so the device-number field is 3 bits wide. Writing 0x0A to index 0x07 therefore tests that the upper bits are dropped, and random device selections reach every bank. With the default 8-bit index, all 208 banked offsets and all 48 global indices can be drawn at random. Directed cases cover the 0x87 resynchronisation, the exit command, and the case where a wrong value written to index 0x02 must not close the port.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int IDX_SPACE = 256;
    localparam int GLOB_CNT  = 48;
    localparam int BANK_SZ   = IDX_SPACE - GLOB_CNT;

    localparam logic [7:0]  IDX_EXIT  = 8'h02;
    localparam logic [7:0]  EXIT_CODE = 8'h02;
    localparam logic [7:0]  IDX_LDN   = 8'h07;
    localparam logic [7:0]  IDX_ID_HI = 8'h20;
    localparam logic [7:0]  IDX_ID_LO = 8'h21;
    localparam logic [15:0] CHIP_ID   = 16'h8712;
    localparam logic [7:0]  LOCKED_RD = 8'hFF;

    function automatic logic [7:0] unlock_byte(input logic [1:0] pos);
        case (pos)
            2'd0:    unlock_byte = 8'h87;
            2'd1:    unlock_byte = 8'h01;
            default: unlock_byte = 8'h55;
        endcase
    endfunction

    typedef struct packed {
        logic       unlocked;
        logic [7:0] idx;
        logic [7:0] rdata;
    } port_state_t;

endpackage

// File: rtl/cfgp_key_seq.sv
module cfgp_key_seq
    import cfgp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       step,
    input  logic [7:0] byte_in,
    output logic       done
);

    logic [1:0] pos_q, pos_d;

    always_comb begin
        pos_d = pos_q;
        done  = 1'b0;
        if (step) begin
            if (byte_in == unlock_byte(pos_q)) begin
                if (pos_q == 2'd3) begin
                    done  = 1'b1;
                    pos_d = 2'd0;
                end else begin
                    pos_d = pos_q + 2'd1;
                end
            end else begin
                pos_d = (byte_in == unlock_byte(2'd0)) ? 2'd1 : 2'd0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pos_q <= 2'd0;
        else     pos_q <= pos_d;
    end

endmodule

// File: rtl/cfgp_global_regs.sv
module cfgp_global_regs
    import cfgp_pkg::*;
#(
    parameter int NUM_DEV = 8,
    localparam int LDN_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
    localparam int GIDX_W = $clog2(GLOB_CNT)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       rd_byte,
    output logic [LDN_W-1:0] dev_sel,
    output logic             exit_req
);

    typedef struct {
        logic [7:0]       store [GLOB_CNT];
        logic [LDN_W-1:0] ldn;
    } glob_state_t;

    glob_state_t g_q, g_d;
    logic        in_range;

    assign in_range = (int'(idx) < GLOB_CNT);

    always_comb begin
        g_d      = g_q;
        exit_req = 1'b0;
        if (wr_en && in_range) begin
            case (idx)
                IDX_EXIT:             exit_req = (wdata == EXIT_CODE);
                IDX_LDN:              g_d.ldn = wdata[LDN_W-1:0];
                IDX_ID_HI, IDX_ID_LO: ;
                default:              g_d.store[idx[GIDX_W-1:0]] = wdata;
            endcase
        end
    end

    always_comb begin
        case (idx)
            IDX_EXIT:  rd_byte = 8'h00;
            IDX_LDN:   rd_byte = 8'(g_q.ldn);
            IDX_ID_HI: rd_byte = CHIP_ID[15:8];
            IDX_ID_LO: rd_byte = CHIP_ID[7:0];
            default:   rd_byte = in_range ? g_q.store[idx[GIDX_W-1:0]] : 8'h00;
        endcase
    end

    assign dev_sel = g_q.ldn;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < GLOB_CNT; i++) g_q.store[i] <= 8'h00;
            g_q.ldn <= '0;
        end else begin
            g_q <= g_d;
        end
    end

endmodule

// File: rtl/cfgp_dev_banks.sv
module cfgp_dev_banks
    import cfgp_pkg::*;
#(
    parameter int NUM_DEV = 8,
    localparam int LDN_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [LDN_W-1:0] dev,
    input  logic [7:0]       idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       rd_byte
);

    logic [7:0] mem_q [NUM_DEV][BANK_SZ];
    logic [7:0] mem_d [NUM_DEV][BANK_SZ];
    logic [7:0] off;
    logic       hit;

    assign off = idx - 8'(GLOB_CNT);
    assign hit = (int'(idx) >= GLOB_CNT) && (int'(dev) < NUM_DEV);

    always_comb begin
        mem_d = mem_q;
        if (wr_en && hit) mem_d[dev][off] = wdata;
    end

    assign rd_byte = hit ? mem_q[dev][off] : 8'h00;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int d = 0; d < NUM_DEV; d++)
                for (int o = 0; o < BANK_SZ; o++)
                    mem_q[d][o] <= 8'h00;
        end else begin
            mem_q <= mem_d;
        end
    end

endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
    import cfgp_pkg::*;
#(
    parameter int NUM_DEV = 8,
    localparam int LDN_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       key_wr,
    input  logic       data_wr,
    input  logic       data_rd,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       cfg_mode
);

    port_state_t      st_q, st_d;
    logic             seq_done, exit_req, is_glob;
    logic             glob_wr, bank_wr;
    logic [7:0]       glob_rd, bank_rd;
    logic [LDN_W-1:0] dev_sel;
    logic [7:0]       sel_idx;

    assign sel_idx = st_q.idx;
    assign is_glob = (int'(st_q.idx) < GLOB_CNT);
    assign glob_wr = data_wr && st_q.unlocked && is_glob;
    assign bank_wr = data_wr && st_q.unlocked && !is_glob;

    cfgp_key_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .step    (key_wr && !st_q.unlocked),
        .byte_in (wdata),
        .done    (seq_done)
    );

    cfgp_global_regs #(.NUM_DEV(NUM_DEV)) u_glob (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (glob_wr),
        .idx      (st_q.idx),
        .wdata    (wdata),
        .rd_byte  (glob_rd),
        .dev_sel  (dev_sel),
        .exit_req (exit_req)
    );

    cfgp_dev_banks #(.NUM_DEV(NUM_DEV)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bank_wr),
        .dev     (dev_sel),
        .idx     (st_q.idx),
        .wdata   (wdata),
        .rd_byte (bank_rd)
    );

    always_comb begin
        st_d = st_q;
        if (key_wr && st_q.unlocked) st_d.idx = wdata;
        if (seq_done)                st_d.unlocked = 1'b1;
        if (exit_req)                st_d.unlocked = 1'b0;
        if (data_rd) begin
            if (!st_q.unlocked) st_d.rdata = LOCKED_RD;
            else if (is_glob)   st_d.rdata = glob_rd;
            else                st_d.rdata = bank_rd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.unlocked <= 1'b0;
            st_q.idx      <= 8'h00;
            st_q.rdata    <= LOCKED_RD;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata    = st_q.rdata;
    assign cfg_mode = st_q.unlocked;

endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker (
    input logic       clk,
    input logic       rst,
    input logic       key_wr,
    input logic       data_wr,
    input logic       data_rd,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       cfg_mode,
    input logic [7:0] sel_idx
);

    p_entry_key_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_mode) |-> ($past(key_wr) && $past(wdata) == 8'h55));

    p_index_load_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode && key_wr) |=> (sel_idx == $past(wdata)));

    p_locked_read_r3: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !cfg_mode) |=> (rdata == 8'hFF));

    p_exit_cmd_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode && data_wr && sel_idx == 8'h02 && wdata == 8'h02) |=> !cfg_mode);

    p_exit_only_cmd_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_mode) |-> ($past(data_wr) && $past(sel_idx) == 8'h02));

    p_id_low_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode && data_rd && sel_idx == 8'h21) |=> (rdata == 8'h12));

    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !data_rd |=> $stable(rdata));

endmodule

bind cfg_port_ctrl cfgp_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .key_wr   (key_wr),
    .data_wr  (data_wr),
    .data_rd  (data_rd),
    .wdata    (wdata),
    .rdata    (rdata),
    .cfg_mode (cfg_mode),
    .sel_idx  (sel_idx)
);

// File: tb/sim_cfg_port_ctrl.sv
module sim_cfg_port_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       key_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       cfg_mode;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [7:0] m_glob [48];
    logic [7:0] m_bank [8][208];
    logic [2:0] m_ldn;
    logic       m_unl;
    logic [7:0] m_idx;
    int         m_kpos;

    always #2.5 clk = ~clk;

    cfg_port_ctrl u0 (
        .clk(clk), .rst(rst), .key_wr(key_wr), .data_wr(data_wr),
        .data_rd(data_rd), .wdata(wdata), .rdata(rdata), .cfg_mode(cfg_mode)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] key_at(input int p);
        return (p == 0) ? 8'h87 : (p == 1) ? 8'h01 : 8'h55;
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < 48; i++) m_glob[i] = 8'h00;
        for (int d = 0; d < 8; d++)
            for (int o = 0; o < 208; o++) m_bank[d][o] = 8'h00;
        m_ldn = 3'd0; m_unl = 1'b0; m_idx = 8'h00; m_kpos = 0;
    endfunction

    function automatic logic [7:0] exp_read();
        if (!m_unl) return 8'hFF;
        case (m_idx)
            8'h02: return 8'h00;
            8'h07: return {5'd0, m_ldn};
            8'h20: return 8'h87;
            8'h21: return 8'h12;
            default: return (m_idx < 8'h30) ? m_glob[m_idx] : m_bank[m_ldn][m_idx - 8'h30];
        endcase
    endfunction

    function automatic string tag_now();
        if (!m_unl) return "R3";
        if (m_idx == 8'h02) return "R5";
        if (m_idx == 8'h07) return "R6";
        if (m_idx == 8'h20 || m_idx == 8'h21) return "R7";
        return (m_idx < 8'h30) ? "R8" : "R9";
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        model_reset();
        chk(cfg_mode == 1'b0, "R11 mode", cfg_mode, 0);
        chk(rdata == 8'hFF, "R11 rdata", rdata, 8'hFF);
    endtask

    task automatic key_write(input logic [7:0] b, input string tag);
        @(negedge clk); key_wr = 1'b1; wdata = b;
        @(negedge clk); key_wr = 1'b0;
        if (m_unl) m_idx = b;
        else if (b == key_at(m_kpos)) begin
            if (m_kpos == 3) begin m_unl = 1'b1; m_kpos = 0; end
            else m_kpos++;
        end else m_kpos = (b == 8'h87) ? 1 : 0;
        chk(cfg_mode == m_unl, tag, cfg_mode, m_unl);
    endtask

    task automatic data_write(input logic [7:0] b, input string tag);
        @(negedge clk); data_wr = 1'b1; wdata = b;
        @(negedge clk); data_wr = 1'b0;
        if (m_unl) begin
            if (m_idx == 8'h02) begin if (b == 8'h02) m_unl = 1'b0; end
            else if (m_idx == 8'h07) m_ldn = b[2:0];
            else if (m_idx == 8'h20 || m_idx == 8'h21) ;
            else if (m_idx < 8'h30) m_glob[m_idx] = b;
            else m_bank[m_ldn][m_idx - 8'h30] = b;
        end
        chk(cfg_mode == m_unl, tag, cfg_mode, m_unl);
    endtask

    task automatic data_read(input string tag);
        logic [7:0] e;
        e = exp_read();
        @(negedge clk); data_rd = 1'b1;
        @(negedge clk); data_rd = 1'b0;
        chk(rdata == e, tag, rdata, e);
    endtask

    task automatic unlock();
        for (int i = 0; i < 4; i++) key_write(key_at(i), "R1 key");
    endtask

    task automatic access(input logic [7:0] i, input logic [7:0] v, input string tag);
        key_write(i, "R4 index");
        data_write(v, tag);
    endtask

    task automatic read_at(input logic [7:0] i);
        key_write(i, "R4 index");
        data_read(tag_now());
    endtask

    function automatic logic [7:0] pick_idx();
        case ($urandom % 8)
            0: return 8'h02;
            1: return 8'h07;
            2: return 8'h20 + 8'($urandom % 2);
            3: return 8'($urandom % 48);
            default: return 8'h30 + 8'($urandom % 208);
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] hold;
        void'($urandom(32'd5150));
        model_reset();
        do_reset();

        // R3: locked port ignores writes and reads 0xFF
        data_read("R3 locked read");
        data_write(8'h5A, "R3 locked write");

        // R1: exact key, no unlock before the fourth byte
        key_write(8'h87, "R1 b1"); key_write(8'h01, "R1 b2");
        key_write(8'h55, "R1 b3");
        chk(cfg_mode == 1'b0, "R1 early", cfg_mode, 0);
        key_write(8'h55, "R1 b4");
        chk(cfg_mode == 1'b1, "R1 open", cfg_mode, 1);

        // R3: the locked write did not reach index 0x00
        read_at(8'h00);

        // R7: identifier, read-only
        read_at(8'h20); read_at(8'h21);
        access(8'h20, 8'h00, "R7 write hi"); data_read("R7 hi kept");
        access(8'h21, 8'hFF, "R7 write lo"); data_read("R7 lo kept");

        // R6: device number keeps low bits only
        access(8'h07, 8'h0A, "R6 write"); data_read("R6 masked");

        // R9: banked storage per device
        access(8'h30, 8'hA2, "R9 dev2");
        access(8'h07, 8'h05, "R6 sel5");
        access(8'h30, 8'hB5, "R9 dev5");
        access(8'h07, 8'h02, "R6 sel2");
        read_at(8'h30);
        chk(rdata == 8'hA2, "R9 dev2 kept", rdata, 8'hA2);

        // R8: global byte shared across devices
        access(8'h2F, 8'h3C, "R8 write");
        access(8'h07, 8'h06, "R6 sel6");
        read_at(8'h2F);
        chk(rdata == 8'h3C, "R8 shared", rdata, 8'h3C);

        // R12: rdata holds without a read strobe
        hold = rdata;
        key_write(8'hFF, "R4 index");
        data_write(8'h11, "R9 write");
        chk(rdata == hold, "R12 hold", rdata, hold);

        // R5: wrong value keeps port open, 0x02 closes it
        access(8'h02, 8'h05, "R5 no exit");
        chk(cfg_mode == 1'b1, "R5 still open", cfg_mode, 1);
        data_read("R5 reads zero");
        data_write(8'h02, "R5 exit");
        chk(cfg_mode == 1'b0, "R5 closed", cfg_mode, 0);
        data_read("R3 after exit");

        // R2: resync on 0x87, and a broken sequence
        key_write(8'h87, "R2"); key_write(8'h01, "R2");
        key_write(8'h87, "R2"); key_write(8'h01, "R2");
        key_write(8'h55, "R2"); key_write(8'h55, "R2 resync");
        chk(cfg_mode == 1'b1, "R2 resync open", cfg_mode, 1);
        access(8'h02, 8'h02, "R5 exit");
        key_write(8'h87, "R2"); key_write(8'h01, "R2");
        key_write(8'h55, "R2"); key_write(8'h00, "R2");
        key_write(8'h55, "R2"); key_write(8'h55, "R2 broken");
        chk(cfg_mode == 1'b0, "R2 stays locked", cfg_mode, 0);

        // R10: contents survive exit and re-entry
        unlock();
        key_write(8'h07, "R4 index"); data_read("R10 ldn kept");
        read_at(8'h2F); read_at(8'hFF);
        access(8'h07, 8'h02, "R6 sel2"); read_at(8'h30);
        chk(rdata == 8'hA2, "R10 bank kept", rdata, 8'hA2);

        // R11: reset clears contents
        do_reset();
        unlock();
        read_at(8'h30); read_at(8'h2F); read_at(8'h07);

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            case ($urandom % 10)
                0: unlock();
                1: key_write(($urandom % 2) ? key_at($urandom % 4) : 8'($urandom), "R2 rand key");
                2: access(8'h02, ($urandom % 2) ? 8'h02 : 8'($urandom), "R5 rand");
                3, 4: key_write(pick_idx(), "R4 rand index");
                5, 6: data_write(8'($urandom), "R10 rand write");
                default: data_read(tag_now());
            endcase
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule